// File: doc/BRIEF.md
# Banked Operand Memory with Row and Column Transfers

This block is the operand store of a 4x4 processing grid. It is made of sixteen small banks, each 256 words of 16 bits, laid out as four bank rows by four bank columns. Bank (r,c) sits at the grid position it feeds. Every access works on one shared address. That address comes from a sequential counter, which can be loaded and which steps by one after an access that asks for it. Only the banks that an access touches receive an enable.

A read takes four words from one bank row or one bank column, or all sixteen words at once. The four words are placed on a 64-bit lane bus, and the result is also deposited into a 4x4 register grid. The deposit goes into one grid row or one grid column, so a bank column can be turned into a grid row and the reverse. If a bank column is read into successive grid rows, with the address stepping by one each time, the grid fills with time-shifted sample rows, as a four-tap filter needs. A write stores the four 16-bit lanes of an input word into one bank row or one bank column. It can also broadcast the same four lanes into every bank row.

Top module: `opmem_top`

## Requirements
- R1: After reset, `addr` is 0, `addrWrap` is 0, `rdValid` is 0, `laneOut` is 0 and `gridOut` is 0.
- R2: `bankEn` has bit r*4+c for bank (r,c). In the cycle an access is presented, it is high exactly on the banks involved. A row access enables bits sel*4..sel*4+3. A column access enables bits sel, sel+4, sel+8 and sel+12. The full shape enables all 16. `bankEn` is zero when no access is presented.
- R3: `accShape` encodes 0 row-to-row, 1 column-to-row, 2 row-to-column, 3 column-to-column and 4 full. A write stores lane k (`wrData[16k+15:16k]`) at the current address. Shapes 0 and 1 store it into bank (dstSel,k). Shapes 2 and 3 store it into bank (k,dstSel). Shape 4 stores it into bank (r,k) for every r.
- R4: For a read, `rdValid` is high for exactly the one cycle after the access and `laneOut` is valid in that cycle. Lane k is bank (srcSel,k) for shapes 0 and 2, bank (k,srcSel) for shapes 1 and 3, and bank (0,k) for shape 4. Lane 0 is in the least significant bits.
- R5: Two cycles after a read, `gridOut` is updated. The grid entry (r,c) is at `gridOut[(4r+c)*16 +: 16]`. Shapes 0 and 1 write lane k into entry (dstSel,k). Shapes 2 and 3 write lane k into entry (k,dstSel). All other entries keep their values, and the grid is unchanged when no read completes.
- R6: A full read (shape 4) loads every grid entry (r,c) from bank (r,c) at the current address.
- R7: Shape codes 5, 6 and 7 are ignored. No bank is enabled, no data changes, no read completes and the address does not step.
- R8: When `addrLoad` is high, `addr` takes `addrInit` after the clock edge, and this takes priority over stepping. An access with `accIncr` high and no load advances `addr` by one. Without `accIncr` the address holds. An access in the same cycle as a load uses the old address.
- R9: A step from 255 goes to 0, and `addrWrap` is high for exactly the one cycle after that step.
- R10: Four column-to-row reads of bank column c with `accIncr`, into grid rows 0 to 3 from start address a, leave grid entry (r,k) equal to bank (k,c) at address a+r.
- R11: `laneOut` keeps the data of the last read while writes or ignored accesses take place, including writes to the same banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access presented this cycle |
| accWrite | input | 1 | 1 write, 0 read |
| accShape | input | 3 | Transfer shape code |
| srcSel | input | 2 | Bank row or column read from |
| dstSel | input | 2 | Grid row/column filled by a read, or bank row/column written |
| accIncr | input | 1 | Step the address after this access |
| wrData | input | 64 | Four 16-bit write lanes |
| addrLoad | input | 1 | Load the address counter |
| addrInit | input | 8 | Value to load |
| bankEn | output | 16 | Per-bank enable of the current access |
| laneOut | output | 64 | Four words of the last read |
| gridOut | output | 256 | 4x4 register grid, 16 bits per entry |
| rdValid | output | 1 | laneOut holds a fresh read |
| addr | output | 8 | Current address |
| addrWrap | output | 1 | Address stepped from 255 to 0 |

## Verification
The bench first fills all 1024 addresses through row writes, so the counter wraps four times. Each wrap must raise `addrWrap` for a single cycle, and a design that ignored the wrap would leave the flag low. Transposing reads (column-to-row, row-to-column) and column or broadcast writes are checked against a bench model. A design that mixed up the bank index or the lane index would place words in the wrong grid entries or the wrong banks. A load in the same cycle as a stepping access must win. The ignored shape codes must leave the enables, the data and the address alone. `laneOut` must hold across writes, where a design that updated it on every enable would show stale or foreign words.

// File: rtl/opmem_pkg.sv
package opmem_pkg;
  localparam int GRID  = 4;
  localparam int WIDTH = 16;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam int SELW  = $clog2(GRID);
  localparam int NBANK = GRID * GRID;
  localparam int LANEW = GRID * WIDTH;
  localparam int GRIDW = NBANK * WIDTH;

  typedef enum logic [2:0] {
    SH_ROW_ROW = 3'd0,
    SH_COL_ROW = 3'd1,
    SH_ROW_COL = 3'd2,
    SH_COL_COL = 3'd3,
    SH_FULL    = 3'd4
  } shape_e;

  typedef enum logic [1:0] {
    DST_ROW = 2'd0,
    DST_COL = 2'd1,
    DST_ALL = 2'd2
  } dst_e;

  typedef struct packed {
    logic [NBANK-1:0] bankEn;
    logic             bankWe;
    logic             rdStart;
    logic             srcCol;
    logic             srcAll;
    logic [SELW-1:0]  srcSel;
    dst_e             dstKind;
    logic [SELW-1:0]  dstSel;
    logic [AW-1:0]    addr;
  } strobe_t;
endpackage

// File: rtl/opmem_bank.sv
module opmem_bank #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdata <= '0;
    else if (en && !we)    rdata <= mem[addr];
  end

  // R11: an idle or writing bank keeps its read register
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(en && !we) |=> $stable(rdata));
endmodule

// File: rtl/opmem_ctrl.sv
module opmem_ctrl
  import opmem_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic            accWrite,
  input  logic [2:0]      accShape,
  input  logic [SELW-1:0] srcSel,
  input  logic [SELW-1:0] dstSel,
  input  logic            accIncr,
  input  logic            addrLoad,
  input  logic [AW-1:0]   addrInit,
  output strobe_t         stb,
  output logic [AW-1:0]   addr,
  output logic            addrWrap
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic            shapeOk;
  logic            act;
  logic            memAll;
  logic            memCol;
  logic [SELW-1:0] memSel;
  logic            readCol;
  logic            writeCol;

  assign shapeOk  = (accShape <= SH_FULL);
  assign act      = accValid && shapeOk;
  assign readCol  = (accShape == SH_COL_ROW) || (accShape == SH_COL_COL);
  assign writeCol = (accShape == SH_ROW_COL) || (accShape == SH_COL_COL);
  assign memAll   = (accShape == SH_FULL);
  assign memCol   = accWrite ? writeCol : readCol;
  assign memSel   = accWrite ? dstSel : srcSel;

  always_comb begin
    stb         = '0;
    stb.bankWe  = act && accWrite;
    stb.rdStart = act && !accWrite;
    stb.srcCol  = readCol;
    stb.srcAll  = memAll;
    stb.srcSel  = srcSel;
    stb.dstSel  = dstSel;
    stb.addr    = addr;
    if (memAll)        stb.dstKind = DST_ALL;
    else if (writeCol) stb.dstKind = DST_COL;
    else               stb.dstKind = DST_ROW;
    for (int r = 0; r < GRID; r++) begin
      for (int c = 0; c < GRID; c++) begin
        stb.bankEn[r*GRID + c] = act && (memAll ||
          (memCol ? (SELW'(c) == memSel) : (SELW'(r) == memSel)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= '0;
      addrWrap <= 1'b0;
    end else begin
      addrWrap <= 1'b0;
      if (addrLoad) begin
        addr <= addrInit;
      end else if (act && accIncr) begin
        addr     <= (addr == LAST) ? '0 : addr + 1'b1;
        addrWrap <= (addr == LAST);
      end
    end
  end

  // R2: nothing is enabled without a presented access
  p_idle_no_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (stb.bankEn == '0));
  // R2: an accepted access touches a row/column (4 banks) or the full grid
  p_enable_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    act |-> (($countones(stb.bankEn) == GRID) || ($countones(stb.bankEn) == NBANK)));
  // R7: unsupported codes enable nothing
  p_bad_shape_r7: assert property (@(posedge clk) disable iff (!rstN)
    !shapeOk |-> (stb.bankEn == '0) && !stb.rdStart && !stb.bankWe);
  // R8: stepping access advances the counter by one
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (act && accIncr && !addrLoad) |=>
      (addr == (($past(addr) == LAST) ? '0 : $past(addr) + 1'b1)));
  // R8: load wins
  p_addr_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> (addr == $past(addrInit)));
  // R9: wrap flag only on the zero address
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    addrWrap |-> (addr == '0));
endmodule

// File: rtl/opmem_datapath.sv
module opmem_datapath
  import opmem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [LANEW-1:0] wrData,
  output logic [LANEW-1:0] laneOut,
  output logic [GRIDW-1:0] gridOut,
  output logic             rdValid
);
  logic [WIDTH-1:0] bankRd [NBANK];
  logic [WIDTH-1:0] laneW  [GRID];
  logic [WIDTH-1:0] grid   [GRID][GRID];

  logic            capValid;
  logic            capSrcCol;
  logic            capSrcAll;
  logic [SELW-1:0] capSrcSel;
  dst_e            capDstKind;
  logic [SELW-1:0] capDstSel;

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      logic [WIDTH-1:0] wd;
      assign wd = (stb.dstKind == DST_COL) ? wrData[r*WIDTH +: WIDTH]
                                           : wrData[c*WIDTH +: WIDTH];
      opmem_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rstN  (rstN),
        .en    (stb.bankEn[r*GRID + c]),
        .we    (stb.bankWe),
        .addr  (stb.addr),
        .wdata (wd),
        .rdata (bankRd[r*GRID + c])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid   <= 1'b0;
      capSrcCol  <= 1'b0;
      capSrcAll  <= 1'b0;
      capSrcSel  <= '0;
      capDstKind <= DST_ROW;
      capDstSel  <= '0;
    end else begin
      capValid <= stb.rdStart;
      if (stb.rdStart) begin
        capSrcCol  <= stb.srcCol;
        capSrcAll  <= stb.srcAll;
        capSrcSel  <= stb.srcSel;
        capDstKind <= stb.dstKind;
        capDstSel  <= stb.dstSel;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < GRID; k++) begin
      int rowIdx;
      rowIdx = capSrcAll ? 0 : int'(capSrcSel);
      if (capSrcCol && !capSrcAll) laneW[k] = bankRd[k*GRID + int'(capSrcSel)];
      else                         laneW[k] = bankRd[rowIdx*GRID + k];
      laneOut[k*WIDTH +: WIDTH] = laneW[k];
    end
  end

  assign rdValid = capValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < GRID; r++)
        for (int c = 0; c < GRID; c++)
          grid[r][c] <= '0;
    end else if (capValid) begin
      for (int r = 0; r < GRID; r++) begin
        for (int c = 0; c < GRID; c++) begin
          if (capDstKind == DST_ALL)
            grid[r][c] <= bankRd[r*GRID + c];
          else if (capDstKind == DST_ROW && SELW'(r) == capDstSel)
            grid[r][c] <= laneW[c];
          else if (capDstKind == DST_COL && SELW'(c) == capDstSel)
            grid[r][c] <= laneW[r];
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < GRID; r++)
      for (int c = 0; c < GRID; c++)
        gridOut[(r*GRID + c)*WIDTH +: WIDTH] = grid[r][c];
  end

  // R4: a valid lane word always follows an accepted read
  p_valid_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(stb.rdStart));
  // R5: the grid moves only when a read completes
  p_grid_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> $stable(gridOut));
endmodule

// File: rtl/opmem_top.sv
module opmem_top
  import opmem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [2:0]       accShape,
  input  logic [SELW-1:0]  srcSel,
  input  logic [SELW-1:0]  dstSel,
  input  logic             accIncr,
  input  logic [LANEW-1:0] wrData,
  input  logic             addrLoad,
  input  logic [AW-1:0]    addrInit,
  output logic [NBANK-1:0] bankEn,
  output logic [LANEW-1:0] laneOut,
  output logic [GRIDW-1:0] gridOut,
  output logic             rdValid,
  output logic [AW-1:0]    addr,
  output logic             addrWrap
);
  strobe_t stb;

  opmem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .accShape (accShape),
    .srcSel   (srcSel),
    .dstSel   (dstSel),
    .accIncr  (accIncr),
    .addrLoad (addrLoad),
    .addrInit (addrInit),
    .stb      (stb),
    .addr     (addr),
    .addrWrap (addrWrap)
  );

  opmem_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .laneOut (laneOut),
    .gridOut (gridOut),
    .rdValid (rdValid)
  );

  assign bankEn = stb.bankEn;
endmodule

// File: tb/opmem_top_tb.sv
module opmem_top_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         accValid, accWrite, accIncr, addrLoad;
  logic [2:0]   accShape;
  logic [1:0]   srcSel, dstSel;
  logic [63:0]  wrData;
  logic [7:0]   addrInit;
  logic [15:0]  bankEn;
  logic [63:0]  laneOut;
  logic [255:0] gridOut;
  logic         rdValid;
  logic [7:0]   addr;
  logic         addrWrap;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [15:0] mdl   [16][256];
  logic [15:0] mGrid [4][4];
  logic [7:0]  mAddr;
  logic [63:0] lastLanes;

  always #10 clk = ~clk;

  opmem_top u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accShape(accShape), .srcSel(srcSel), .dstSel(dstSel), .accIncr(accIncr),
    .wrData(wrData), .addrLoad(addrLoad), .addrInit(addrInit),
    .bankEn(bankEn), .laneOut(laneOut), .gridOut(gridOut), .rdValid(rdValid),
    .addr(addr), .addrWrap(addrWrap)
  );

  task automatic chk(input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expEn(input logic wr, input logic [2:0] sh,
                                        input logic [1:0] s, input logic [1:0] d);
    logic [15:0] e = '0;
    logic col, all;
    logic [1:0] sel;
    if (sh > 3'd4) return '0;
    all = (sh == 3'd4);
    col = wr ? (sh == 3'd2 || sh == 3'd3) : (sh == 3'd1 || sh == 3'd3);
    sel = wr ? d : s;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        e[r*4+c] = all || (col ? (c == sel) : (r == sel));
    return e;
  endfunction

  function automatic logic [255:0] flatGrid();
    logic [255:0] f;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        f[(r*4+c)*16 +: 16] = mGrid[r][c];
    return f;
  endfunction

  task automatic doAccess(input logic wr, input logic [2:0] sh, input logic [1:0] s,
                          input logic [1:0] d, input logic inc, input logic [63:0] data,
                          input logic ld, input logic [7:0] ldVal);
    logic [7:0]  oldA = mAddr;
    logic        ok   = (sh <= 3'd4);
    logic        isRd = ok && !wr;
    logic        expWrap;
    logic [63:0] expLanes = '0;
    accValid = 1'b1; accWrite = wr; accShape = sh; srcSel = s; dstSel = d;
    accIncr = inc; wrData = data; addrLoad = ld; addrInit = ldVal;
    #1;
    chk(ok ? "R2 bankEn" : "R7 bankEn", {240'b0, bankEn}, {240'b0, expEn(wr, sh, s, d)});
    if (isRd) begin
      for (int k = 0; k < 4; k++) begin
        if (sh == 3'd1 || sh == 3'd3) expLanes[k*16 +: 16] = mdl[k*4+s][oldA];
        else if (sh == 3'd4)          expLanes[k*16 +: 16] = mdl[k][oldA];
        else                          expLanes[k*16 +: 16] = mdl[s*4+k][oldA];
      end
    end
    if (ok && wr) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          if (expEn(wr, sh, s, d)[r*4+c])
            mdl[r*4+c][oldA] = (sh == 3'd2 || sh == 3'd3) ? data[r*16 +: 16] : data[c*16 +: 16];
    end
    expWrap = !ld && ok && inc && (oldA == 8'd255);
    if (ld)            mAddr = ldVal;
    else if (ok && inc) mAddr = oldA + 8'd1;
    @(negedge clk);
    accValid = 1'b0; addrLoad = 1'b0; accIncr = 1'b0;
    chk("R8 addr", {248'b0, addr}, {248'b0, mAddr});
    chk("R9 addrWrap", {255'b0, addrWrap}, {255'b0, expWrap});
    chk("R4 rdValid", {255'b0, rdValid}, {255'b0, isRd});
    if (isRd) begin
      chk("R4 laneOut", {192'b0, laneOut}, {192'b0, expLanes});
      lastLanes = expLanes;
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          if (sh == 3'd4) mGrid[r][c] = mdl[r*4+c][oldA];
          else if ((sh == 3'd0 || sh == 3'd1) && r == d) mGrid[r][c] = expLanes[c*16 +: 16];
          else if ((sh == 3'd2 || sh == 3'd3) && c == d) mGrid[r][c] = expLanes[r*16 +: 16];
        end
    end else begin
      chk("R11 laneOut held", {192'b0, laneOut}, {192'b0, lastLanes});
    end
    @(negedge clk);
    chk(sh == 3'd4 ? "R6 gridOut" : (ok ? "R5 gridOut" : "R7 gridOut"), gridOut, flatGrid());
    chk("R4 rdValid drop", {255'b0, rdValid}, 256'b0);
    chk("R9 addrWrap drop", {255'b0, addrWrap}, 256'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1234abcd);
    rstN = 1'b0; accValid = 0; accWrite = 0; accShape = 0; srcSel = 0; dstSel = 0;
    accIncr = 0; wrData = 0; addrLoad = 0; addrInit = 0;
    mAddr = 0; lastLanes = 0;
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) mGrid[r][c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 addr", {248'b0, addr}, 256'b0);
    chk("R1 addrWrap", {255'b0, addrWrap}, 256'b0);
    chk("R1 rdValid", {255'b0, rdValid}, 256'b0);
    chk("R1 laneOut", {192'b0, laneOut}, 256'b0);
    chk("R1 gridOut", gridOut, 256'b0);
    chk("R1 bankEn", {240'b0, bankEn}, 256'b0);

    // R3/R9: fill every bank row, wrapping the counter each pass
    for (int row = 0; row < 4; row++)
      for (int a = 0; a < 256; a++)
        doAccess(1'b1, 3'd0, 2'd0, row[1:0], 1'b1, {$urandom, $urandom}, 1'b0, 8'd0);

    // directed shapes at one address (R4, R5, R6)
    doAccess(1'b0, 3'd0, 2'd0, 2'd0, 1'b0, '0, 1'b1, 8'd7);
    for (int sh = 0; sh < 5; sh++)
      doAccess(1'b0, sh[2:0], 2'd2, 2'd1, 1'b0, '0, 1'b0, 8'd0);
    // R3 column and broadcast writes, then readback
    doAccess(1'b1, 3'd3, 2'd0, 2'd3, 1'b0, 64'h4444_3333_2222_1111, 1'b0, 8'd0);
    doAccess(1'b0, 3'd3, 2'd3, 2'd0, 1'b0, '0, 1'b0, 8'd0);
    doAccess(1'b1, 3'd4, 2'd0, 2'd0, 1'b0, 64'hdddd_cccc_bbbb_aaaa, 1'b0, 8'd0);
    doAccess(1'b0, 3'd4, 2'd0, 2'd0, 1'b0, '0, 1'b0, 8'd0);
    // R7 ignored codes, with increment requested
    for (int sh = 5; sh < 8; sh++)
      doAccess(sh[0], sh[2:0], 2'd1, 2'd1, 1'b1, 64'hffff_ffff_ffff_ffff, 1'b0, 8'd0);
    // R8 load wins over a stepping access
    doAccess(1'b0, 3'd0, 2'd1, 2'd2, 1'b1, '0, 1'b1, 8'd254);
    doAccess(1'b0, 3'd1, 2'd0, 2'd0, 1'b1, '0, 1'b0, 8'd0);
    doAccess(1'b0, 3'd1, 2'd0, 2'd1, 1'b1, '0, 1'b0, 8'd0);

    // R10 shifted sample rows
    doAccess(1'b0, 3'd0, 2'd0, 2'd0, 1'b0, '0, 1'b1, 8'd10);
    for (int r = 0; r < 4; r++)
      doAccess(1'b0, 3'd1, 2'd2, r[1:0], 1'b1, '0, 1'b0, 8'd0);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++)
        chk("R10 shifted row", {240'b0, gridOut[(r*4+k)*16 +: 16]},
            {240'b0, mdl[k*4+2][10+r]});

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] sh;
      sh = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      doAccess(($urandom % 3) == 0, sh, 2'($urandom), 2'($urandom), 1'($urandom),
               {$urandom, $urandom}, ($urandom % 16) == 0, 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule